// File: doc/BRIEF.md
# Widening Unsigned Vector Left Shifter

This block is a two-stage pipelined vector unit. It takes one vector of unsigned elements and one unsigned shift count. Each element is zero-extended to twice its width and shifted left by the same count, independently of the other lanes. The widened lanes take twice the storage of the source vector, so they are returned as two result vectors. The first holds the lower half of the lanes and the second holds the upper half. Two condition flags go with the results.

The count comes from either a register-style operand or an immediate operand, picked per operation. Both sources give the same result for the same value. A valid bit travels with the data, and a new operation can enter on every clock. No input value or count can raise a fault, so the operation is safe to issue speculatively. Its only effect is on the outputs.

Top module: `wshl_vec_unit`

## Requirements
- R1: While reset is asserted, and until the first operation reaches the output, `out_valid`, `out_zero`, `out_carry`, `out_r0` and `out_r1` are all zero.
- R2: For lane i with element x and count n < 2*ELEM_W, the result is (x zero-extended to 2*ELEM_W bits) shifted left by n, truncated to 2*ELEM_W bits.
- R3: Lanes 0 to LANES/2-1 go to `out_r0` and lanes LANES/2 to LANES-1 go to `out_r1`. Lane i sits at bits [(i mod LANES/2)*2*ELEM_W +: 2*ELEM_W] of its result vector.
- R4: An operation accepted at a rising edge with `in_valid`=1 appears, with `out_valid`=1, right after the next rising edge. No other operation appears in between.
- R5: One operation is accepted on every edge where `in_valid` is 1. Back-to-back operations leave the pipeline in order, one per cycle.
- R6: A count of 2*ELEM_W or more makes every lane's result zero.
- R7: `in_cnt_src`=0 takes the count from `in_cnt_reg` and `in_cnt_src`=1 takes it from `in_cnt_imm`. The operand that is not selected has no effect. Equal count values from either source give identical results and flags.
- R8: `out_zero` is 1 exactly when `out_valid` is 1 and every bit of `out_r0` and `out_r1` is zero.
- R9: `out_carry` is 1 exactly when `out_valid` is 1 and at least one set bit of some lane ends up at or above bit position 2*ELEM_W after the shift. With a count of 2*ELEM_W or more, this means some element is nonzero.
- R10: In a cycle where `out_valid` is 0, both result vectors and both flags are zero, whatever the inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_vec | input | LANES*ELEM_W | Source vector, lane i at [i*ELEM_W +: ELEM_W] |
| in_cnt_src | input | 1 | Count source: 0 register operand, 1 immediate |
| in_cnt_reg | input | CNT_W | Register-style shift count |
| in_cnt_imm | input | CNT_W | Immediate shift count |
| out_valid | output | 1 | Result present this cycle |
| out_r0 | output | LANES*ELEM_W | Widened results of the lower half of the lanes |
| out_r1 | output | LANES*ELEM_W | Widened results of the upper half of the lanes |
| out_zero | output | 1 | Both result vectors entirely zero |
| out_carry | output | 1 | A set bit was shifted out past the doubled width |

## Verification
The zero flag and the carry flag can both be set in the same cycle. This happens when a nonzero vector is shifted by a count at or above the doubled width: every result bit is cleared, and every source bit is lost off the top. The bench provokes this with counts of exactly 2*ELEM_W and of 200 on nonzero vectors. It expects both flags high together with all-zero result vectors. It also checks that a count just below the limit, on a vector that stays inside the widened lane, raises neither flag.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    // Source of the shift count for one operation
    typedef enum logic {
        CNT_FROM_REG = 1'b0,
        CNT_FROM_IMM = 1'b1
    } cnt_src_e;

endpackage

// File: rtl/wsl_count_sel.sv
module wsl_count_sel
    import wsl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  cnt_src_e           src,
    input  logic [CNT_W-1:0]   cnt_reg,
    input  logic [CNT_W-1:0]   cnt_imm,
    output logic [CNT_W-1:0]   cnt
);

    always_comb begin
        unique case (src)
            CNT_FROM_REG: cnt = cnt_reg;
            CNT_FROM_IMM: cnt = cnt_imm;
            default:      cnt = '0;
        endcase
    end

endmodule

// File: rtl/wsl_lane.sv
module wsl_lane #(
    parameter int ELEM_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [ELEM_W-1:0]   x,
    input  logic [CNT_W-1:0]    cnt,
    output logic [2*ELEM_W-1:0] res,
    output logic                carry
);

    localparam int WIDE_W = 2 * ELEM_W;
    localparam int EXT_W  = 2 * WIDE_W;
    localparam int SH_W   = $clog2(WIDE_W);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WIDE_W);

    logic [EXT_W-1:0] ext;
    logic             saturate;

    assign saturate = (cnt >= LIMIT);

    // With cnt < WIDE_W the top set bit lands below EXT_W, so nothing is lost here
    always_comb begin
        ext = EXT_W'(x) << cnt[SH_W-1:0];
        if (saturate) begin
            res   = '0;
            carry = |x;
        end else begin
            res   = ext[WIDE_W-1:0];
            carry = |ext[EXT_W-1:WIDE_W];
        end
    end

endmodule

// File: rtl/wsl_flag_reduce.sv
module wsl_flag_reduce #(
    parameter int LANES = 4,
    parameter int RES_W = 16
) (
    input  logic [LANES*RES_W-1:0] res_bus,
    input  logic [LANES-1:0]       lane_carry,
    output logic                   all_zero,
    output logic                   any_carry
);

    logic [LANES-1:0] lane_nz;

    for (genvar g = 0; g < LANES; g++) begin : g_nz
        assign lane_nz[g] = |res_bus[g*RES_W +: RES_W];
    end

    assign all_zero  = ~|lane_nz;
    assign any_carry = |lane_carry;

endmodule

// File: rtl/wshl_vec_unit.sv
module wshl_vec_unit
    import wsl_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int LANES  = 4,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*ELEM_W-1:0] in_vec,
    input  logic                    in_cnt_src,
    input  logic [CNT_W-1:0]        in_cnt_reg,
    input  logic [CNT_W-1:0]        in_cnt_imm,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_r0,
    output logic [LANES*ELEM_W-1:0] out_r1,
    output logic                    out_zero,
    output logic                    out_carry
);

    localparam int WIDE_W = 2 * ELEM_W;
    localparam int HALF   = LANES / 2;
    localparam int VEC_W  = LANES * ELEM_W;
    localparam int BUS_W  = LANES * WIDE_W;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WIDE_W);

    // ---------------- stage 1: operand capture ----------------
    logic [CNT_W-1:0] sel_cnt;
    logic             s1_valid;
    logic [VEC_W-1:0] s1_vec;
    logic [CNT_W-1:0] s1_cnt;

    wsl_count_sel #(.CNT_W(CNT_W)) u_cnt (
        .src     (cnt_src_e'(in_cnt_src)),
        .cnt_reg (in_cnt_reg),
        .cnt_imm (in_cnt_imm),
        .cnt     (sel_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_vec   <= '0;
            s1_cnt   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_vec   <= in_valid ? in_vec  : '0;
            s1_cnt   <= in_valid ? sel_cnt : '0;
        end
    end

    // ---------------- stage 2: per-lane widen and shift ----------------
    logic [BUS_W-1:0] lane_res;
    logic [LANES-1:0] lane_cy;
    logic             nx_zero;
    logic             nx_carry;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wsl_lane #(.ELEM_W(ELEM_W), .CNT_W(CNT_W)) u_lane (
            .x     (s1_vec[g*ELEM_W +: ELEM_W]),
            .cnt   (s1_cnt),
            .res   (lane_res[g*WIDE_W +: WIDE_W]),
            .carry (lane_cy[g])
        );
    end

    wsl_flag_reduce #(.LANES(LANES), .RES_W(WIDE_W)) u_flags (
        .res_bus    (lane_res),
        .lane_carry (lane_cy),
        .all_zero   (nx_zero),
        .any_carry  (nx_carry)
    );

    // Lower lanes fill r0, upper lanes fill r1
    logic [VEC_W-1:0] nx_r0;
    logic [VEC_W-1:0] nx_r1;

    for (genvar h = 0; h < HALF; h++) begin : g_split
        assign nx_r0[h*WIDE_W +: WIDE_W] = lane_res[h*WIDE_W +: WIDE_W];
        assign nx_r1[h*WIDE_W +: WIDE_W] = lane_res[(h+HALF)*WIDE_W +: WIDE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_r0    <= '0;
            out_r1    <= '0;
            out_zero  <= 1'b0;
            out_carry <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_r0    <= s1_valid ? nx_r0 : '0;
            out_r1    <= s1_valid ? nx_r1 : '0;
            out_zero  <= s1_valid & nx_zero;
            out_carry <= s1_valid & nx_carry;
        end
    end

    // ---------------- assertions ----------------
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r4_two_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r10_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_r0 == '0 && out_r1 == '0 && !out_zero && !out_carry));

    a_r8_zero_matches_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_r0 == '0 && out_r1 == '0)));

    a_r6_large_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_cnt >= LIMIT) |=> (out_valid && out_r0 == '0 && out_r1 == '0));

    a_r9_carry_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_carry |-> out_valid);

endmodule

// File: tb/sim_wshl_vec_unit.sv
module sim_wshl_vec_unit;

    localparam int EW = 8;
    localparam int LN = 4;
    localparam int CW = 8;
    localparam int W2 = 2 * EW;
    localparam int VW = LN * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          in_cnt_src = 1'b0;
    logic [CW-1:0] in_cnt_reg = '0;
    logic [CW-1:0] in_cnt_imm = '0;
    logic          out_valid;
    logic [VW-1:0] out_r0, out_r1;
    logic          out_zero, out_carry;

    wshl_vec_unit #(.ELEM_W(EW), .LANES(LN), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_cnt_src(in_cnt_src), .in_cnt_reg(in_cnt_reg), .in_cnt_imm(in_cnt_imm),
        .out_valid(out_valid), .out_r0(out_r0), .out_r1(out_r1),
        .out_zero(out_zero), .out_carry(out_carry)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [VW-1:0] r0;
        logic [VW-1:0] r1;
        logic          z;
        logic          c;
        int            stamp;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic exp_t model(input logic [VW-1:0] v, input logic [CW-1:0] n);
        exp_t e;
        e.r0 = '0; e.r1 = '0; e.c = 1'b0;
        for (int i = 0; i < LN; i++) begin
            logic [EW-1:0]   x;
            logic [2*W2-1:0] full;
            logic [W2-1:0]   r;
            logic            cy;
            x = v[i*EW +: EW];
            if (n >= CW'(W2)) begin
                r  = '0;
                cy = (x != 0);
            end else begin
                full = (2*W2)'(x) << n;
                r    = full[W2-1:0];
                cy   = |full[2*W2-1:W2];
            end
            if (i < LN/2) e.r0[i*W2 +: W2] = r;
            else          e.r1[(i-LN/2)*W2 +: W2] = r;
            e.c = e.c | cy;
        end
        e.z = (e.r0 == '0) && (e.r1 == '0);
        return e;
    endfunction

    // driver: one operation per call, pushes expected item
    task automatic issue(input logic [VW-1:0] v, input logic [CW-1:0] n,
                         input bit from_imm, input logic [CW-1:0] other, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        in_vec     = v;
        in_cnt_src = from_imm;
        in_cnt_reg = from_imm ? other : n;
        in_cnt_imm = from_imm ? n : other;
        e = model(v, n);
        e.stamp = cyc;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_vec     = 32'hDEAD_BEEF;   // garbage while idle, R10
            in_cnt_reg = 8'd3;
            in_cnt_imm = 8'd7;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected result", 64'(out_r0), 64'(0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.stamp + 2, {"R4 R5 latency ", e.tag}, 64'(cyc), 64'(e.stamp + 2));
                    chk(out_r0 == e.r0, {"R2 R3 r0 ", e.tag}, 64'(out_r0), 64'(e.r0));
                    chk(out_r1 == e.r1, {"R2 R3 r1 ", e.tag}, 64'(out_r1), 64'(e.r1));
                    chk(out_zero == e.z, {"R8 zero ", e.tag}, 64'(out_zero), 64'(e.z));
                    chk(out_carry == e.c, {"R9 carry ", e.tag}, 64'(out_carry), 64'(e.c));
                end
            end else begin
                chk(out_r0 == '0 && out_r1 == '0 && !out_zero && !out_carry,
                    "R10 bubble outputs", {out_r0, out_r1}, 64'(0));
            end
        end
    end

    initial begin
        in_vec = 32'hFFFF_FFFF;
        in_cnt_reg = 8'd1;
        in_valid = 1'b1;             // ignored while in reset, R1
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_zero && !out_carry && out_r0 == '0 && out_r1 == '0,
            "R1 reset state", {out_r0, out_r1}, 64'(0));
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && out_r0 == '0 && out_r1 == '0, "R1 after release",
            64'(out_valid), 64'(0));
        mon_on = 1'b1;

        // R2 R3 lane order with distinct lanes, count zero
        issue(32'h80FF_0201, 8'd0,  1'b0, 8'd0,  "R3 order n0");
        // R5 back-to-back run
        issue(32'h80FF_0201, 8'd3,  1'b0, 8'd77, "R5 n3");
        issue(32'hA53C_817E, 8'd8,  1'b1, 8'd1,  "R5 n8");
        issue(32'hA53C_817E, 8'd9,  1'b0, 8'd2,  "R9 n9");
        issue(32'h0000_0001, 8'd15, 1'b1, 8'd0,  "R2 n15");
        issue(32'h8000_0000, 8'd15, 1'b0, 8'd0,  "R9 top lane n15");
        idle(2);
        // R6 with both flags together
        issue(32'h1234_5678, 8'd16,  1'b0, 8'd1, "R6 n16");
        issue(32'hFFFF_FFFF, 8'd200, 1'b1, 8'd4, "R6 n200");
        issue(32'h0000_0000, 8'd16,  1'b0, 8'd0, "R6 zero vec");
        // R8 zero vector, small count
        issue(32'h0000_0000, 8'd5,   1'b0, 8'd0, "R8 zero vec");
        idle(1);
        // R7 same count via each source, unused operand differs
        issue(32'h00C3_5A01, 8'd5, 1'b0, 8'd99,  "R7 reg");
        issue(32'h00C3_5A01, 8'd5, 1'b1, 8'd250, "R7 imm");
        issue(32'h00C3_5A01, 8'd5, 1'b1, 8'd0,   "R7 imm2");
        idle(4);
        while (q.size() != 0) @(negedge clk);
        idle(1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule